// File: doc/BRIEF.md
# Frame-Activity Power Sequencer

This block decides when a voice codec is awake or asleep. It watches the rising edges of the transmit and receive frame syncs and a dual-use pin. That pin carries either a master clock or a static level that controls power. The block sleeps out of reset. It wakes on the first frame-sync edge while the dual-use pin is low or toggling. It goes back to sleep after a programmable idle interval with no sync edge. A pin held high forces sleep whatever the sync activity.

Three outputs gate the codec's outputs and receive path:
- An enable for the serial data output. It opens only from the second transmit sync after wake.
- An enable for the analog output.
- A receive mute. It covers a programmable interval after each wake.

A separate select tells the receive timing to borrow the transmit master clock whenever the dual-use pin is static.

The block has no data path, so every pin is a plain level with no handshake. The frame syncs are expected to be synchronous to `clk`. The dual-use pin may be asynchronous; it passes through a two-stage synchronizer. All intervals come from per-timer prescalers. `TICK_DIV` sets the system clocks per tick, and `IDLE_TICKS` and `MUTE_TICKS` set the tick counts. This lets a simulation use short values.

Top module: `fa_pwr_seq`

## Requirements
- R1: After reset `pwr_down`=1, `dx_oe`=0, `ana_oe`=0 and `rx_mute`=1.
- R2: The block leaves power-down only on a rising edge of `fs_tx` or `fs_rx` while the pin is classified low or clock. Without a sync edge it stays powered down indefinitely.
- R3: When no sync edge arrives, `pwr_down` rises exactly TICK_DIV*IDLE_TICKS+1 cycles after the clock edge that sampled the last sync rising edge. Every sync edge restarts this count.
- R4: `pwr_down` falls at the first clock edge that samples a waking sync edge. `ana_oe` always equals the inverse of `pwr_down`.
- R5: `dx_oe` is 1 only while powered up and only once two `fs_tx` rising edges have been seen since the latest wake. A waking `fs_tx` edge counts as the first. Power-down clears the count.
- R6: A pin held high and classified high forces `pwr_down`=1 within one cycle of classification, even with continuing sync edges.
- R7: The pin is classified clock if it toggles within a window of DET_WIN cycles. Otherwise it is classified by its level. `rx_clk_from_tx` is 1 when the pin is static (low or high) and 0 when it is a clock.
- R8: `rx_mute` is 1 while powered down and for exactly TICK_DIV*MUTE_TICKS cycles after the waking clock edge. Later sync edges do not extend it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mclk_pdn_pin | input | 1 | Dual-use pin: receive master clock or static power control |
| fs_tx | input | 1 | Transmit frame sync, synchronous to clk |
| fs_rx | input | 1 | Receive frame sync, synchronous to clk |
| pwr_down | output | 1 | 1 while the codec is powered down |
| dx_oe | output | 1 | Serial data output enable |
| ana_oe | output | 1 | Analog output enable |
| rx_mute | output | 1 | Receive output mute |
| rx_clk_from_tx | output | 1 | 1 routes the transmit master clock to receive timing |

## Verification
A vector table drives the pin static low, toggling, static high and low again, then applies one transmit sync each time. This separates the three pin classes by their effect on the clock select and on whether the sync is allowed to wake the block. Directed sequences then cover the remaining behaviours:
- A wake by a receive-only sync, to show that it does not count toward the data-enable.
- Exact cycle boundaries of the idle and mute intervals, with the mute run under a steady sync stream.
- A pin forced high during active syncs.
- A second wake after idle sleep, to show that the transmit-sync count restarts.

// File: rtl/fa_pwr_pkg.sv
package fa_pwr_pkg;
  typedef enum logic [1:0] {
    PM_LOW   = 2'd0,
    PM_HIGH  = 2'd1,
    PM_CLOCK = 2'd2
  } pin_mode_e;
endpackage

// File: rtl/fa_pin_classify.sv
module fa_pin_classify
  import fa_pwr_pkg::*;
#(
  parameter int unsigned DET_WIN = 8
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pin,
  output pin_mode_e mode
);
  localparam int unsigned WW = $clog2(DET_WIN + 1);
  localparam logic [WW-1:0] WIN_LAST = WW'(DET_WIN - 1);

  logic [1:0]    sync_q;
  logic          lvl_q;
  logic          seen_q;
  logic [WW-1:0] win_q;
  logic          toggle;

  assign toggle = sync_q[1] ^ lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      lvl_q  <= 1'b1;
      seen_q <= 1'b0;
      win_q  <= '0;
      mode   <= PM_HIGH;
    end else begin
      sync_q <= {sync_q[0], pin};
      lvl_q  <= sync_q[1];
      if (win_q == WIN_LAST) begin
        win_q  <= '0;
        seen_q <= 1'b0;
        if (seen_q || toggle) mode <= PM_CLOCK;
        else if (sync_q[1])   mode <= PM_HIGH;
        else                  mode <= PM_LOW;
      end else begin
        win_q  <= win_q + 1'b1;
        seen_q <= seen_q | toggle;
      end
    end
  end

  // R7: classification only changes at the end of a detection window
  a_r7_mode_at_window_end: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode) |-> $past(win_q) == WIN_LAST);
endmodule

// File: rtl/fa_interval_timer.sv
module fa_interval_timer #(
  parameter int unsigned TICK_DIV = 2048,
  parameter int unsigned TICKS    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic done
);
  localparam int unsigned PW = $clog2(TICK_DIV + 1);
  localparam int unsigned CW = $clog2(TICKS + 1);
  localparam logic [PW-1:0] PRE_LAST = PW'(TICK_DIV - 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(TICKS - 1);

  logic [PW-1:0] pre_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
      done  <= 1'b1;
    end else if (restart) begin
      pre_q <= '0;
      cnt_q <= '0;
      done  <= 1'b0;
    end else if (!done) begin
      if (pre_q == PRE_LAST) begin
        pre_q <= '0;
        if (cnt_q == CNT_LAST) done  <= 1'b1;
        else                   cnt_q <= cnt_q + 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

  // R3/R8: an expired interval stays expired until restarted
  a_r8_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    done && !restart |=> done);
  // R3/R8: a restart always opens a fresh interval
  a_r3_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !done);
endmodule

// File: rtl/fa_pwr_seq.sv
module fa_pwr_seq
  import fa_pwr_pkg::*;
#(
  parameter int unsigned DET_WIN    = 8,
  parameter int unsigned TICK_DIV   = 2048,
  parameter int unsigned IDLE_TICKS = 2,
  parameter int unsigned MUTE_TICKS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mclk_pdn_pin,
  input  logic fs_tx,
  input  logic fs_rx,
  output logic pwr_down,
  output logic dx_oe,
  output logic ana_oe,
  output logic rx_mute,
  output logic rx_clk_from_tx
);
  pin_mode_e  mode;
  logic       fs_tx_q, fs_rx_q;
  logic       tx_rise, any_rise, wake;
  logic       idle_done, mute_done;
  logic [1:0] tx_cnt_q;

  fa_pin_classify #(.DET_WIN(DET_WIN)) u_cls (
    .clk(clk), .rst_n(rst_n), .pin(mclk_pdn_pin), .mode(mode));

  fa_interval_timer #(.TICK_DIV(TICK_DIV), .TICKS(IDLE_TICKS)) u_idle (
    .clk(clk), .rst_n(rst_n), .restart(any_rise), .done(idle_done));

  fa_interval_timer #(.TICK_DIV(TICK_DIV), .TICKS(MUTE_TICKS)) u_mute (
    .clk(clk), .rst_n(rst_n), .restart(wake), .done(mute_done));

  assign tx_rise  = fs_tx & ~fs_tx_q;
  assign any_rise = tx_rise | (fs_rx & ~fs_rx_q);
  assign wake     = pwr_down & any_rise & (mode != PM_HIGH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_tx_q  <= 1'b0;
      fs_rx_q  <= 1'b0;
      pwr_down <= 1'b1;
      tx_cnt_q <= 2'd0;
    end else begin
      fs_tx_q <= fs_tx;
      fs_rx_q <= fs_rx;
      if (mode == PM_HIGH) begin
        pwr_down <= 1'b1;
        tx_cnt_q <= 2'd0;
      end else if (any_rise) begin
        pwr_down <= 1'b0;
        if (pwr_down)                      tx_cnt_q <= {1'b0, tx_rise};
        else if (tx_rise && tx_cnt_q != 2) tx_cnt_q <= tx_cnt_q + 1'b1;
      end else if (idle_done) begin
        pwr_down <= 1'b1;
        tx_cnt_q <= 2'd0;
      end
    end
  end

  assign dx_oe          = ~pwr_down & (tx_cnt_q == 2'd2);
  assign ana_oe         = ~pwr_down;
  assign rx_mute        = pwr_down | ~mute_done;
  assign rx_clk_from_tx = (mode != PM_CLOCK);

  // R6: a static-high pin forces power-down on the next edge
  a_r6_high_forces_down: assert property (@(posedge clk) disable iff (!rst_n)
    mode == PM_HIGH |=> pwr_down);
  // R2/R4: waking needs a sampled sync edge
  a_r4_wake_on_sync: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_down) |-> $past(fs_tx & ~fs_tx_q) || $past(fs_rx & ~fs_rx_q));
  // R3: sleep only on idle expiry or forced high
  a_r3_sleep_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_down) |-> $past(idle_done) || $past(mode == PM_HIGH));
  // R5: data enable opens only on a transmit sync edge
  a_r5_dx_after_tx: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dx_oe) |-> $past(fs_tx & ~fs_tx_q));
endmodule

// File: tb/fa_pwr_seq_bench.sv
module fa_pwr_seq_bench;
  localparam int unsigned TDIV = 4;
  localparam int unsigned IDLE = 5;
  localparam int unsigned MUTE = 10;
  localparam int IDLE_CYC = TDIV * IDLE;
  localparam int MUTE_CYC = TDIV * MUTE;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin_level = 1'b0;
  logic pin_clk_en = 1'b0;
  logic tog = 1'b0;
  logic fs_tx = 1'b0, fs_rx = 1'b0;
  logic pin;
  logic pwr_down, dx_oe, ana_oe, rx_mute, rx_clk_from_tx;
  int   tests = 0, fails = 0;

  always #10 clk = ~clk;
  always @(negedge clk) tog <= ~tog;
  assign pin = pin_clk_en ? tog : pin_level;

  fa_pwr_seq #(.DET_WIN(8), .TICK_DIV(TDIV), .IDLE_TICKS(IDLE), .MUTE_TICKS(MUTE))
    u_fa_pwr_seq (
      .clk(clk), .rst_n(rst_n), .mclk_pdn_pin(pin), .fs_tx(fs_tx), .fs_rx(fs_rx),
      .pwr_down(pwr_down), .dx_oe(dx_oe), .ana_oe(ana_oe), .rx_mute(rx_mute),
      .rx_clk_from_tx(rx_clk_from_tx));

  // each vector: pin kind (0 low, 1 high, 2 clock), expected select, expected pwr_down after a tx sync
  typedef struct packed { logic [1:0] kind; logic sel; logic pd; } vec_t;
  localparam vec_t VECS [4] = '{
    '{2'd0, 1'b1, 1'b0},
    '{2'd2, 1'b0, 1'b0},
    '{2'd1, 1'b1, 1'b1},
    '{2'd0, 1'b1, 1'b0}};

  task automatic chk(input string req, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // one-cycle pulse; returns at the negedge right after the sampling posedge
  task automatic pulse(input logic tx);
    @(negedge clk);
    if (tx) fs_tx = 1'b1; else fs_rx = 1'b1;
    @(negedge clk);
    fs_tx = 1'b0; fs_rx = 1'b0;
  endtask

  task automatic set_pin(input logic [1:0] kind);
    pin_clk_en = (kind == 2'd2);
    pin_level  = (kind == 2'd1);
    wait_n(40);
  endtask

  initial begin
    wait_n(3);
    chk("R1 pwr_down", pwr_down, 1'b1);
    chk("R1 dx_oe", dx_oe, 1'b0);
    chk("R1 ana_oe", ana_oe, 1'b0);
    chk("R1 rx_mute", rx_mute, 1'b1);
    rst_n = 1'b1;

    // vector walk: pin class vs select and wake permission (R7, R2, R6)
    for (int v = 0; v < 4; v++) begin
      set_pin(VECS[v].kind);
      chk("R7 select", rx_clk_from_tx, VECS[v].sel);
      pulse(1'b1);
      chk("R2/R6 wake by pin class", pwr_down, VECS[v].pd);
      chk("R4 ana_oe tracks", ana_oe, ~VECS[v].pd);
      wait_n(IDLE_CYC + 5);
      chk("R3 back to sleep", pwr_down, 1'b1);
    end

    // R2: pin low but no sync edge keeps the block asleep
    wait_n(60);
    chk("R2 no sync stays down", pwr_down, 1'b1);

    // R5: receive-only wake, then transmit syncs
    pulse(1'b0);
    chk("R4 wake on rx", pwr_down, 1'b0);
    chk("R5 dx off after rx wake", dx_oe, 1'b0);
    wait_n(3);
    pulse(1'b1);
    chk("R5 dx off after first tx", dx_oe, 1'b0);
    wait_n(3);
    pulse(1'b1);
    chk("R5 dx on after second tx", dx_oe, 1'b1);

    // R3: exact idle boundary after the last sync
    wait_n(IDLE_CYC);
    chk("R3 still up at boundary", pwr_down, 1'b0);
    wait_n(1);
    chk("R3 down one cycle later", pwr_down, 1'b1);
    chk("R5 dx cleared by sleep", dx_oe, 1'b0);

    // R8 and R5: tx wake, steady rx syncs, mute boundary, tx count restart
    pulse(1'b1);
    chk("R5 dx off after tx wake", dx_oe, 1'b0);
    for (int k = 1; k <= MUTE_CYC; k++) begin
      fs_rx = (k % 10 == 0);
      @(negedge clk);
      if (k == MUTE_CYC - 1) chk("R8 mute held", rx_mute, 1'b1);
      if (k == MUTE_CYC)     chk("R8 mute released", rx_mute, 1'b0);
    end
    fs_rx = 1'b0;
    chk("R8 still awake", pwr_down, 1'b0);
    pulse(1'b1);
    chk("R5 dx on after second tx since wake", dx_oe, 1'b1);

    // R6: pin forced high with continuing syncs
    pin_level = 1'b1;
    for (int k = 0; k < 4; k++) begin
      pulse(1'b0);
      wait_n(7);
    end
    chk("R6 forced down", pwr_down, 1'b1);
    chk("R6 dx off", dx_oe, 1'b0);
    chk("R8 mute while down", rx_mute, 1'b1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule